// File: doc/BRIEF.md
# Fetch-Group History Bit Predictor

This block is a dynamic one-bit branch direction predictor for an instruction fetch unit. Instead of tracking each branch separately, it keeps one history bit for every aligned group of four instructions. On every fetch cycle the bit of the group that holds the fetch address comes out together with that group. When the bit is set, the group is taken to contain a branch that will be taken, and the fetch stream is steered to a predicted target that the fetch unit supplies.

When a branch resolves, the resolved direction is written straight into its group's bit. Branches that share a group therefore share one bit, and the last one to resolve decides the next prediction. When a cache line is refilled or invalidated, the bits of all groups in that line go back to not taken. A lookup is combinational, and an update becomes visible on the cycle after it is presented.

Top module: `fetch_group_predictor`

## Requirements
- R1: While reset is asserted and right after it, every group's history bit reads 0 (not taken), and `redirectValid` is 0 even when `fetchValid` is 1.
- R2: The group index is `fetchPc[9:4]` (the same slice of `resolvePc`). Bits [1:0] are the byte offset, bits [3:2] pick the instruction inside the group, and bits above bit 9 are ignored, so 64 groups are tracked. Addresses 0x020 and 0x02C share a group, and so do 0x030 and 0x430.
- R3: `redirectValid` is 1 exactly when `fetchValid` is 1 and the looked-up bit is 1. While `redirectValid` is 1, `redirectPc` equals `fetchTarget`.
- R4: `historyBit` is the stored bit of the group addressed by `fetchPc` in the same cycle, combinationally. It does not change while no update or clear has happened and `fetchPc` is stable.
- R5: A resolve with `resolveValid`=1 writes `resolveTaken` (1 = taken) into the bit of its group. The new value can be read from the next cycle on, and other groups are left unchanged.
- R6: Resolves to different instructions in the same group overwrite one shared bit. The most recent outcome wins.
- R7: When a lookup and a resolve address the same group in the same cycle, the lookup returns the value the bit had before the resolve.
- R8: An invalidate with `invalValid`=1 clears to 0 the bits of both groups in the 32-byte line addressed by `invalPc[9:5]`. Groups in other lines keep their values.
- R9: If a resolve falls into the line being invalidated in the same cycle, the clear wins and the bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch request is present this cycle |
| fetchPc | input | 32 | Fetch address |
| fetchTarget | input | 32 | Predicted target supplied by the fetch unit |
| historyBit | output | 1 | History bit of the fetched group |
| redirectValid | output | 1 | Redirect the fetch stream this cycle |
| redirectPc | output | 32 | Address to redirect to |
| resolveValid | input | 1 | A branch outcome is being reported |
| resolvePc | input | 32 | Address of the resolved branch |
| resolveTaken | input | 1 | Resolved direction, 1 = taken |
| invalValid | input | 1 | A cache line is being refilled or invalidated |
| invalPc | input | 32 | Address inside the affected line |

## Verification
The bench targets index aliasing from two directions. Offsets inside a group must hit one bit, and addresses 1 KiB apart must fold onto the same entry. A design that sliced the wrong bits would let a neighbouring group change or would miss the alias. The bench also presents a lookup and an update to the same group in one cycle, which catches a write-through path that returns the new value too early. Invalidates are checked over both groups of a line while a far group is watched, which exposes a clear that is too wide or too narrow. A resolve that collides with an invalidate of its line must end up not taken, so a design with the priority reversed leaves the bit set.

// File: rtl/fgp_pkg.sv
package fgp_pkg;
  // Write strobes sent from the control to the history array
  typedef struct packed {
    logic wrEn;   // write one group bit
    logic wrVal;  // value to write
    logic clrEn;  // clear every group of one line
  } fgpStrobe_t;
endpackage

// File: rtl/fgp_ctrl.sv
module fgp_ctrl
  import fgp_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int IDX_LSB = 4,
  parameter int IDX_W = 6,
  parameter int SUB_W = 1
) (
  input  logic                   fetchValid,
  input  logic [PC_W-1:0]        fetchPc,
  input  logic [PC_W-1:0]        fetchTarget,
  input  logic                   resolveValid,
  input  logic [PC_W-1:0]        resolvePc,
  input  logic                   resolveTaken,
  input  logic                   invalValid,
  input  logic [PC_W-1:0]        invalPc,
  input  logic                   readBit,
  output logic [IDX_W-1:0]       readIdx,
  output logic [IDX_W-1:0]       wrIdx,
  output logic [IDX_W-SUB_W-1:0] clrLine,
  output fgpStrobe_t             strobe,
  output logic                   redirectValid,
  output logic [PC_W-1:0]        redirectPc
);
  localparam int LINE_W = IDX_W - SUB_W;

  logic [LINE_W-1:0] resLine;
  logic              clashLine;

  always_comb begin
    readIdx   = fetchPc[IDX_LSB +: IDX_W];
    wrIdx     = resolvePc[IDX_LSB +: IDX_W];
    clrLine   = invalPc[IDX_LSB + SUB_W +: LINE_W];
    resLine   = wrIdx[IDX_W-1:SUB_W];
    clashLine = invalValid && (resLine == clrLine);

    strobe.clrEn = invalValid;
    strobe.wrEn  = resolveValid && !clashLine;
    strobe.wrVal = resolveTaken;

    redirectValid = fetchValid && readBit;
    redirectPc    = fetchTarget;
  end
endmodule

// File: rtl/fgp_history.sv
module fgp_history
  import fgp_pkg::*;
#(
  parameter int GROUP_COUNT = 64,
  parameter int IDX_W = 6,
  parameter int SUB_W = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fgpStrobe_t             strobe,
  input  logic [IDX_W-1:0]       readIdx,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [IDX_W-SUB_W-1:0] clrLine,
  output logic                   readBit
);
  logic [GROUP_COUNT-1:0] histQ;

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : gGroup
    localparam logic [IDX_W-1:0] G_IDX = IDX_W'(g);
    logic clrHit;
    logic wrHit;

    always_comb begin
      clrHit = strobe.clrEn && (G_IDX[IDX_W-1:SUB_W] == clrLine);
      wrHit  = strobe.wrEn && (G_IDX == wrIdx);
    end

    always_ff @(posedge clk) begin
      if (!rstN)       histQ[g] <= 1'b0;
      else if (clrHit) histQ[g] <= 1'b0;
      else if (wrHit)  histQ[g] <= strobe.wrVal;
    end
  end

  // Read sees the registered value: same-cycle writes land next cycle
  assign readBit = histQ[readIdx];
endmodule

// File: rtl/fetch_group_predictor.sv
module fetch_group_predictor
  import fgp_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int INSN_BYTES = 4,
  parameter int GROUP_INSNS = 4,
  parameter int GROUP_COUNT = 64,
  parameter int GROUPS_PER_LINE = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] fetchTarget,
  output logic            historyBit,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken,
  input  logic            invalValid,
  input  logic [PC_W-1:0] invalPc
);
  localparam int IDX_LSB = $clog2(INSN_BYTES) + $clog2(GROUP_INSNS);
  localparam int IDX_W   = $clog2(GROUP_COUNT);
  localparam int SUB_W   = $clog2(GROUPS_PER_LINE);
  localparam int LINE_W  = IDX_W - SUB_W;

  fgpStrobe_t        strobe;
  logic [IDX_W-1:0]  readIdx;
  logic [IDX_W-1:0]  wrIdx;
  logic [LINE_W-1:0] clrLine;
  logic              readBit;

  fgp_ctrl #(
    .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .SUB_W(SUB_W)
  ) u_ctrl (
    .fetchValid(fetchValid), .fetchPc(fetchPc), .fetchTarget(fetchTarget),
    .resolveValid(resolveValid), .resolvePc(resolvePc),
    .resolveTaken(resolveTaken), .invalValid(invalValid), .invalPc(invalPc),
    .readBit(readBit), .readIdx(readIdx), .wrIdx(wrIdx), .clrLine(clrLine),
    .strobe(strobe), .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  fgp_history #(
    .GROUP_COUNT(GROUP_COUNT), .IDX_W(IDX_W), .SUB_W(SUB_W)
  ) u_hist (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readIdx(readIdx),
    .wrIdx(wrIdx), .clrLine(clrLine), .readBit(readBit)
  );

  assign historyBit = readBit;
endmodule

// File: rtl/fgp_checker.sv
module fgp_checker #(
  parameter int PC_W = 32,
  parameter int INSN_BYTES = 4,
  parameter int GROUP_INSNS = 4,
  parameter int GROUP_COUNT = 64,
  parameter int GROUPS_PER_LINE = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            fetchValid,
  input logic [PC_W-1:0] fetchPc,
  input logic [PC_W-1:0] fetchTarget,
  input logic            historyBit,
  input logic            redirectValid,
  input logic [PC_W-1:0] redirectPc,
  input logic            resolveValid,
  input logic [PC_W-1:0] resolvePc,
  input logic            resolveTaken,
  input logic            invalValid,
  input logic [PC_W-1:0] invalPc
);
  localparam int LSB    = $clog2(INSN_BYTES) + $clog2(GROUP_INSNS);
  localparam int IW     = $clog2(GROUP_COUNT);
  localparam int SW     = $clog2(GROUPS_PER_LINE);
  localparam int LW     = IW - SW;

  logic [IW-1:0] fIdx, rIdx;
  logic [LW-1:0] fLine, rLine, iLine;
  assign fIdx  = fetchPc[LSB +: IW];
  assign rIdx  = resolvePc[LSB +: IW];
  assign fLine = fetchPc[LSB + SW +: LW];
  assign rLine = resolvePc[LSB + SW +: LW];
  assign iLine = invalPc[LSB + SW +: LW];

  p_redirect_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (fetchValid && historyBit && redirectPc == fetchTarget));

  p_redirect_when_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && historyBit) |-> redirectValid);

  p_update_visible_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && !(invalValid && rLine == iLine)) |=>
      ((fIdx != $past(rIdx)) || (historyBit == $past(resolveTaken))));

  p_inval_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    invalValid |=> ((fLine != $past(iLine)) || !historyBit));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(resolveValid) && !$past(invalValid) && $stable(fetchPc))
      |-> $stable(historyBit));
endmodule

bind fetch_group_predictor fgp_checker #(
  .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .GROUP_INSNS(GROUP_INSNS),
  .GROUP_COUNT(GROUP_COUNT), .GROUPS_PER_LINE(GROUPS_PER_LINE)
) u_fgpChk (.*);

// File: tb/fetch_group_predictor_bench.sv
module fetch_group_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic [31:0] fetchTarget = '0;
  logic        historyBit;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        resolveValid = 1'b0;
  logic [31:0] resolvePc = '0;
  logic        resolveTaken = 1'b0;
  logic        invalValid = 1'b0;
  logic [31:0] invalPc = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_group_predictor u_fetch_group_predictor (.*);

  // {resolvePc, taken, lookupPc, expected bit}
  localparam logic [65:0] VECS [NVEC] = '{
    {32'h010, 1'b1, 32'h010, 1'b1},  // R5
    {32'h020, 1'b1, 32'h02C, 1'b1},  // R2 same group
    {32'h024, 1'b0, 32'h020, 1'b0},  // R6 overwrite
    {32'h030, 1'b1, 32'h430, 1'b1},  // R2 upper bits ignored
    {32'h040, 1'b1, 32'h050, 1'b0},  // R5 neighbour unchanged
    {32'h050, 1'b1, 32'h040, 1'b1},  // R5
    {32'h3F0, 1'b1, 32'h3F0, 1'b1},  // R5 top group
    {32'h010, 1'b0, 32'h010, 1'b0}   // R6 back to not taken
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] pc, logic valid);
    @(negedge clk);
    fetchPc = pc;
    fetchValid = valid;
    #1;
  endtask

  task automatic resolve(logic [31:0] pc, logic taken, logic inv, logic [31:0] ipc);
    @(negedge clk);
    resolveValid = 1'b1; resolvePc = pc; resolveTaken = taken;
    invalValid = inv; invalPc = ipc;
    @(negedge clk);
    resolveValid = 1'b0; invalValid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    look(32'h000, 1'b1);
    chk("R1 bit in reset", {31'd0, historyBit}, 32'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    look(32'h3F0, 1'b1);
    chk("R1 bit after reset", {31'd0, historyBit}, 32'd0);
    chk("R1 no redirect", {31'd0, redirectValid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      resolve(VECS[i][65:34], VECS[i][33], 1'b0, 32'h0);
      look(VECS[i][32:1], 1'b0);
      chk($sformatf("R5/R6/R2 vector %0d", i), {31'd0, historyBit},
          {31'd0, VECS[i][0]});
    end

    // R3: redirect on set bit, target passed through
    fetchTarget = 32'hCAFE_0100;
    look(32'h034, 1'b1);
    chk("R3 redirect", {31'd0, redirectValid}, 32'd1);
    chk("R3 target", redirectPc, 32'hCAFE_0100);
    look(32'h034, 1'b0);
    chk("R3 no fetch no redirect", {31'd0, redirectValid}, 32'd0);
    chk("R4 bit without fetch", {31'd0, historyBit}, 32'd1);
    look(32'h010, 1'b1);
    chk("R3 clear bit no redirect", {31'd0, redirectValid}, 32'd0);

    // R7: same-cycle lookup and update of one group
    look(32'h030, 1'b1);
    resolveValid = 1'b1; resolvePc = 32'h038; resolveTaken = 1'b0;
    #1;
    chk("R7 old value before edge", {31'd0, historyBit}, 32'd1);
    @(negedge clk);
    resolveValid = 1'b0;
    #1;
    chk("R7 new value next cycle", {31'd0, historyBit}, 32'd0);

    // R8: invalidate line 0x040..0x05F
    resolve(32'h000, 1'b0, 1'b1, 32'h048);
    look(32'h040, 1'b0);
    chk("R8 first group cleared", {31'd0, historyBit}, 32'd0);
    look(32'h05C, 1'b0);
    chk("R8 second group cleared", {31'd0, historyBit}, 32'd0);
    look(32'h3F0, 1'b0);
    chk("R8 other line kept", {31'd0, historyBit}, 32'd1);

    // R9: resolve collides with invalidate of its line
    resolve(32'h070, 1'b1, 1'b0, 32'h0);
    resolve(32'h060, 1'b1, 1'b1, 32'h07C);
    look(32'h060, 1'b0);
    chk("R9 clear wins same group", {31'd0, historyBit}, 32'd0);
    look(32'h070, 1'b0);
    chk("R9 clear wins sibling", {31'd0, historyBit}, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule